// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block makes the interrupt requests for one UART channel. Its inputs are the status flags that the channel's buffers and FIFOs already produce: transmit buffer empty, transmit FIFO at trigger level, receive data present, receive FIFO at trigger level, receive FIFO timeout, framing error and overrun error. From these it drives three request lines: transmit, receive and receive-error. The FIFO-enable flag chooses which status flag is the trigger condition for each direction. A small control word sets the request style and the gating for each direction.

Each direction can present its request as a single-cycle pulse or as a held level. A pulse marks the rising edge of the condition. A level follows the condition for as long as it holds. A timeout, when enabled, adds a pulse to the receive request. Errors set sticky flags. If enabled, an error also pulses the error request. The block also holds the loopback path: in loopback the serializer output feeds the deserializer input directly, and the external line is parked at idle.

Top module: `uart_irq_gen`

## Requirements
- R1: After reset, tx_irq_o, rx_irq_o and err_irq_o are 0, and err_flags_o is 0.
- R2: The transmit condition is tx_empty_i when fifo_en_i=0 and tx_trig_i when fifo_en_i=1. The flag that is not selected has no effect on tx_irq_o.
- R3: The receive condition is rx_avail_i when fifo_en_i=0 and rx_trig_i when fifo_en_i=1. The flag that is not selected has no effect on rx_irq_o.
- R4: Pulse style applies when ctrl_i[4]=0 (transmit) or ctrl_i[3]=0 (receive). The request is high for exactly one cycle, in the cycle after the condition rises. It does not fire again while the condition stays high.
- R5: Level style applies when ctrl_i[4]=1 (transmit) or ctrl_i[3]=1 (receive). The request equals the condition as sampled at the previous clock edge.
- R6: With ctrl_i[2]=1 and fifo_en_i=1, a rising rx_tmo_i gives a one-cycle pulse on rx_irq_o in the next cycle. If either gate is 0, rx_tmo_i has no effect.
- R7: With ctrl_i[1]=1, each rising edge of frm_err_i or ovr_err_i gives a one-cycle err_irq_o pulse in the next cycle. With ctrl_i[1]=0, err_irq_o stays 0.
- R8: err_flags_o[0] (framing) and err_flags_o[1] (overrun) are set by a rising edge of their source, whatever the value of ctrl_i[1]. They hold until err_clr_i is sampled high. A new event in the same cycle as a clear leaves its flag set.
- R9: With ctrl_i[0]=1 (loopback), ser_rx_o equals ser_tx_i, pad_tx_o is 1, and pad_rx_i has no effect.
- R10: With ctrl_i[0]=0, pad_tx_o equals ser_tx_i and ser_rx_o equals pad_rx_i, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 5 | Control: [4] tx level, [3] rx level, [2] timeout enable, [1] error enable, [0] loopback |
| fifo_en_i | input | 1 | FIFO mode selected |
| tx_empty_i | input | 1 | Transmit holding buffer empty |
| tx_trig_i | input | 1 | Transmit FIFO at trigger level |
| rx_avail_i | input | 1 | Receive buffer holds data |
| rx_trig_i | input | 1 | Receive FIFO at trigger level |
| rx_tmo_i | input | 1 | Receive FIFO timeout event |
| frm_err_i | input | 1 | Framing error detected |
| ovr_err_i | input | 1 | Overrun error detected |
| err_clr_i | input | 1 | Clear sticky error flags |
| ser_tx_i | input | 1 | Serial data from the serializer |
| ser_rx_o | output | 1 | Serial data to the deserializer |
| pad_tx_o | output | 1 | External serial output line |
| pad_rx_i | input | 1 | External serial input line |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Receive error interrupt request |
| err_flags_o | output | 2 | Sticky error flags: [1] overrun, [0] framing |

## Verification
All internal state here is a registered copy of a condition or a sticky flag, and every such bit reaches a port within one clock. A stale edge-detect copy shows up as a missing pulse or a repeated pulse in the cycle right after the condition changes. A flag that is lost or stuck shows up on err_flags_o in the cycle after the event or the clear. Wrong condition selection appears as a request that follows the unselected flag one cycle after that flag toggles. The loopback path has no state, so any routing fault shows at the pads in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef struct packed {
    logic tx_lvl;
    logic rx_lvl;
    logic tmo_en;
    logic err_en;
    logic loop_en;
  } irq_ctl_t;

  localparam int unsigned CTL_W  = $bits(irq_ctl_t);
  localparam int unsigned N_REQ  = 3;  // tx, rx, rx timeout
  localparam int unsigned REQ_TX = 0;
  localparam int unsigned REQ_RX = 1;
  localparam int unsigned REQ_TO = 2;
  localparam int unsigned N_ERR  = 2;  // [0] framing, [1] overrun
endpackage

// File: rtl/uart_irq_req.sv
module uart_irq_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic lvl_i,
  output logic irq_o
);
  logic cond_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond_i;
      irq_q  <= lvl_i ? cond_i : (cond_i & ~cond_q);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_err.sv
module uart_irq_err #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] evt_q, flags_q, evt_new;
  logic             irq_q;

  assign evt_new = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      evt_q   <= evt_i;
      // new event wins over a simultaneous clear
      flags_q <= (flags_q & ~{N_SRC{clr_i}}) | evt_new;
      irq_q   <= en_i & (|evt_new);
    end
  end

  assign irq_o   = irq_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/uart_irq_loop.sv
module uart_irq_loop #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic loop_en_i,
  input  logic ser_tx_i,
  input  logic pad_rx_i,
  output logic ser_rx_o,
  output logic pad_tx_o
);
  assign ser_rx_o = loop_en_i ? ser_tx_i : pad_rx_i;
  assign pad_tx_o = loop_en_i ? IDLE_LVL : ser_tx_i;
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctrl_i,
  input  logic             fifo_en_i,
  input  logic             tx_empty_i,
  input  logic             tx_trig_i,
  input  logic             rx_avail_i,
  input  logic             rx_trig_i,
  input  logic             rx_tmo_i,
  input  logic             frm_err_i,
  input  logic             ovr_err_i,
  input  logic             err_clr_i,
  input  logic             ser_tx_i,
  output logic             ser_rx_o,
  output logic             pad_tx_o,
  input  logic             pad_rx_i,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             err_irq_o,
  output logic [N_ERR-1:0] err_flags_o
);
  irq_ctl_t         ctl;
  logic [N_REQ-1:0] cond, lvl, req;

  assign ctl = irq_ctl_t'(ctrl_i);

  assign cond[REQ_TX] = fifo_en_i ? tx_trig_i : tx_empty_i;
  assign cond[REQ_RX] = fifo_en_i ? rx_trig_i : rx_avail_i;
  assign cond[REQ_TO] = ctl.tmo_en & fifo_en_i & rx_tmo_i;
  assign lvl[REQ_TX]  = ctl.tx_lvl;
  assign lvl[REQ_RX]  = ctl.rx_lvl;
  assign lvl[REQ_TO]  = 1'b0;  // timeout always pulses

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    uart_irq_req u_req (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cond_i (cond[g]),
      .lvl_i  (lvl[g]),
      .irq_o  (req[g])
    );
  end

  assign tx_irq_o = req[REQ_TX];
  assign rx_irq_o = req[REQ_RX] | req[REQ_TO];

  uart_irq_err #(.N_SRC(N_ERR)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   ({ovr_err_i, frm_err_i}),
    .en_i    (ctl.err_en),
    .clr_i   (err_clr_i),
    .irq_o   (err_irq_o),
    .flags_o (err_flags_o)
  );

  uart_irq_loop #(.IDLE_LVL(1'b1)) u_loop (
    .loop_en_i (ctl.loop_en),
    .ser_tx_i  (ser_tx_i),
    .pad_rx_i  (pad_rx_i),
    .ser_rx_o  (ser_rx_o),
    .pad_tx_o  (pad_tx_o)
  );
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk
  import uart_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CTL_W-1:0] ctrl_i,
  input logic             fifo_en_i,
  input logic             tx_empty_i,
  input logic             tx_trig_i,
  input logic             rx_avail_i,
  input logic             rx_trig_i,
  input logic             rx_tmo_i,
  input logic             frm_err_i,
  input logic             ovr_err_i,
  input logic             err_clr_i,
  input logic             ser_tx_i,
  input logic             ser_rx_o,
  input logic             pad_tx_o,
  input logic             pad_rx_i,
  input logic             tx_irq_o,
  input logic             rx_irq_o,
  input logic             err_irq_o,
  input logic [N_ERR-1:0] err_flags_o
);
  irq_ctl_t ctl;
  assign ctl = irq_ctl_t'(ctrl_i);

  // R4: a transmit pulse never lasts two cycles
  p_tx_pulse_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_irq_o && !ctl.tx_lvl && $past(!ctl.tx_lvl)) |=> !tx_irq_o);

  // R5: level style tracks the selected non-FIFO condition
  p_tx_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctl.tx_lvl) && $past(!fifo_en_i)) |-> (tx_irq_o == $past(tx_empty_i)));

  // R7: error request stays quiet when not enabled
  p_err_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctl.err_en) |-> !err_irq_o);

  // R8: a framing flag holds without a clear
  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_flags_o[0]) && $past(!err_clr_i)) |-> err_flags_o[0]);

  // R9: external line parked idle in loopback
  p_loop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.loop_en |-> (pad_tx_o && (ser_rx_o == ser_tx_i)));

  // R6: timeout ignored outside FIFO mode when no other rx source was high
  p_tmo_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!fifo_en_i) && $past(!rx_avail_i)) |-> !rx_irq_o);
endmodule

bind uart_irq_gen uart_irq_gen_chk u_chk (.*);

// File: tb/uart_irq_gen_test.sv
`timescale 1ns/1ps
module uart_irq_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] ctrl_i = '0;
  logic fifo_en_i = 0, tx_empty_i = 0, tx_trig_i = 0, rx_avail_i = 0, rx_trig_i = 0;
  logic rx_tmo_i = 0, frm_err_i = 0, ovr_err_i = 0, err_clr_i = 0;
  logic ser_tx_i = 1, pad_rx_i = 1;
  logic ser_rx_o, pad_tx_o, tx_irq_o, rx_irq_o, err_irq_o;
  logic [1:0] err_flags_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_irq_gen uut (.*);

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk_i); endtask

  task automatic t_reset();
    rst_ni = 0; step(); step();
    chk("R1 tx", {1'b0, tx_irq_o}, 2'b00);
    chk("R1 rx", {1'b0, rx_irq_o}, 2'b00);
    chk("R1 err", {1'b0, err_irq_o}, 2'b00);
    chk("R1 flags", err_flags_o, 2'b00);
    rst_ni = 1; step();
  endtask

  task automatic t_tx_pulse();
    ctrl_i = 5'b00000; fifo_en_i = 0; tx_empty_i = 0; step(); step();
    tx_empty_i = 1; step();
    chk("R4 tx pulse", {1'b0, tx_irq_o}, 2'b01);
    step(); chk("R4 tx one cycle", {1'b0, tx_irq_o}, 2'b00);
    step(); chk("R4 tx no refire", {1'b0, tx_irq_o}, 2'b00);
    // FIFO mode: empty flag ignored, trigger used (R2)
    fifo_en_i = 1; tx_trig_i = 0; tx_empty_i = 0; step(); step();
    tx_empty_i = 1; step();
    chk("R2 empty ignored in fifo", {1'b0, tx_irq_o}, 2'b00);
    tx_trig_i = 1; step();
    chk("R2 tx trig pulse", {1'b0, tx_irq_o}, 2'b01);
    tx_trig_i = 0; tx_empty_i = 0; fifo_en_i = 0; step(); step();
  endtask

  task automatic t_tx_level();
    ctrl_i = 5'b10000; fifo_en_i = 0; tx_empty_i = 0; step(); step();
    tx_empty_i = 1; step(); step(); step();
    chk("R5 tx level held", {1'b0, tx_irq_o}, 2'b01);
    tx_empty_i = 0; step();
    chk("R5 tx level drops", {1'b0, tx_irq_o}, 2'b00);
    ctrl_i = 5'b00000; step();
  endtask

  task automatic t_rx();
    ctrl_i = 5'b00000; fifo_en_i = 0; step();
    rx_avail_i = 1; step();
    chk("R3 rx avail pulse", {1'b0, rx_irq_o}, 2'b01);
    step(); chk("R4 rx one cycle", {1'b0, rx_irq_o}, 2'b00);
    rx_avail_i = 0; fifo_en_i = 1; ctrl_i = 5'b01000; step();
    rx_avail_i = 1; step(); step();
    chk("R3 avail ignored in fifo", {1'b0, rx_irq_o}, 2'b00);
    rx_trig_i = 1; step(); step();
    chk("R5 rx level on trig", {1'b0, rx_irq_o}, 2'b01);
    rx_trig_i = 0; rx_avail_i = 0; step();
    chk("R5 rx level off", {1'b0, rx_irq_o}, 2'b00);
    ctrl_i = 5'b00000; fifo_en_i = 0; step();
  endtask

  task automatic t_tmo();
    ctrl_i = 5'b00100; fifo_en_i = 1; rx_trig_i = 0; step();
    rx_tmo_i = 1; step();
    chk("R6 timeout pulse", {1'b0, rx_irq_o}, 2'b01);
    step(); chk("R6 timeout one cycle", {1'b0, rx_irq_o}, 2'b00);
    rx_tmo_i = 0; fifo_en_i = 0; step();
    rx_tmo_i = 1; step();
    chk("R6 timeout ignored no fifo", {1'b0, rx_irq_o}, 2'b00);
    rx_tmo_i = 0; fifo_en_i = 1; ctrl_i = 5'b00000; step();
    rx_tmo_i = 1; step();
    chk("R6 timeout ignored disabled", {1'b0, rx_irq_o}, 2'b00);
    rx_tmo_i = 0; fifo_en_i = 0; step();
  endtask

  task automatic t_err();
    ctrl_i = 5'b00010; err_clr_i = 1; step(); err_clr_i = 0; step();
    frm_err_i = 1; step();
    chk("R7 frame irq", {1'b0, err_irq_o}, 2'b01);
    chk("R8 frame flag", err_flags_o, 2'b01);
    step();
    chk("R7 err one cycle", {1'b0, err_irq_o}, 2'b00);
    chk("R8 flag held", err_flags_o, 2'b01);
    frm_err_i = 0; ovr_err_i = 1; step();
    chk("R7 overrun irq", {1'b0, err_irq_o}, 2'b01);
    chk("R8 both flags", err_flags_o, 2'b11);
    ovr_err_i = 0; err_clr_i = 1; step(); err_clr_i = 0;
    chk("R8 cleared", err_flags_o, 2'b00);
    // disabled: flag still set, no irq
    ctrl_i = 5'b00000; step();
    ovr_err_i = 1; step();
    chk("R7 err disabled", {1'b0, err_irq_o}, 2'b00);
    chk("R8 flag without enable", err_flags_o, 2'b10);
    ovr_err_i = 0; step();
    frm_err_i = 1; err_clr_i = 1; step();
    chk("R8 set wins over clear", err_flags_o, 2'b01);
    frm_err_i = 0; err_clr_i = 0; step();
  endtask

  task automatic t_loop();
    ctrl_i = 5'b00000; ser_tx_i = 0; pad_rx_i = 1; #1;
    chk("R10 normal tx", {1'b0, pad_tx_o}, 2'b00);
    chk("R10 normal rx", {1'b0, ser_rx_o}, 2'b01);
    pad_rx_i = 0; #1;
    chk("R10 normal rx low", {1'b0, ser_rx_o}, 2'b00);
    ctrl_i = 5'b00001; ser_tx_i = 0; pad_rx_i = 1; #1;
    chk("R9 pad idle", {1'b0, pad_tx_o}, 2'b01);
    chk("R9 internal loop", {1'b0, ser_rx_o}, 2'b00);
    ser_tx_i = 1; pad_rx_i = 0; #1;
    chk("R9 pad rx ignored", {1'b0, ser_rx_o}, 2'b01);
    ctrl_i = 5'b00000; step();
  endtask

  initial begin
    t_reset();
    t_tx_pulse();
    t_tx_level();
    t_rx();
    t_tmo();
    t_err();
    t_loop();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule